// File: doc/BRIEF.md
# Queue Doorbell Write Decoder

This block sits behind the register port of a storage host controller. It watches 32-bit register writes and handles those that land in the doorbell window. Each accepted write is turned into a queue number and a doorbell kind: either a submission-tail doorbell or a completion-head doorbell. The low 16 bits of the written data become that queue's new pointer. A one-cycle notification pulse tells the rest of the controller what to do next. A submission-tail write asks for the queue's new entries to be serviced. A completion-head write frees completion slots, so that held-back submissions can resume.

Some writes are refused. The controller may be disabled, the target queue may not exist, or the decoded number may be beyond the configured queue count. A refused write leaves every pointer untouched. Instead it raises an error pulse that names the kind (bad submission queue or bad completion queue) and the decoded queue number. The admin pair is queue 0 and follows exactly the same rules. Pointers reset to zero and are held at zero whenever the controller is disabled.

Top module: `dbell_decoder`

## Requirements
- R1: A write whose byte offset is below 0x1000 is outside the doorbell window: it produces no pulse and changes no pointer.
- R2: Inside the window, with rel = offset - 0x1000 and the stride fixed at 4 bytes, the queue number is rel >> 3. Bit 2 of rel set means a completion-head doorbell, and bit 2 clear means a submission-tail doorbell. Bits 1:0 of the offset are ignored.
- R3: Only data bits 15:0 are stored as the pointer value. Bits 31:16 are ignored and never cause an error.
- R4: An accepted submission-tail write updates that queue's tail pointer. One cycle after the strobe, it raises `sq_kick` for one cycle, with `evt_qid` equal to the queue number.
- R5: An accepted completion-head write updates that queue's head pointer. One cycle after the strobe, it raises `cq_kick` for one cycle, with `evt_qid` equal to the queue number.
- R6: While `ctrl_enable` is 0, any window write, including writes to queue 0, is dropped. One cycle later it raises `err_sq` (tail kind) or `err_cq` (head kind), with `evt_qid` equal to the decoded number.
- R7: A write to a queue whose bit in `sq_created`/`cq_created` is 0, or whose number is NUM_Q or more, is dropped. It raises the matching error pulse with the decoded number.
- R8: At most one of `sq_kick`, `cq_kick`, `err_sq`, `err_cq` is high in any cycle, and each pulse follows a write strobe in the previous cycle.
- R9: After reset, every pointer reads 0. One cycle after `ctrl_enable` is sampled low, every pointer reads 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 14 | Byte offset of the write in the controller register space |
| wr_data | input | 32 | Write data |
| ctrl_enable | input | 1 | Controller enable bit |
| sq_created | input | 16 | Bit i set: submission queue i exists |
| cq_created | input | 16 | Bit i set: completion queue i exists |
| sq_tail_flat | output | 256 | Tail pointer of submission queue i at bits 16i+15:16i |
| cq_head_flat | output | 256 | Head pointer of completion queue i at bits 16i+15:16i |
| sq_kick | output | 1 | Pulse: service new submission entries |
| cq_kick | output | 1 | Pulse: completion slots freed |
| err_sq | output | 1 | Pulse: invalid submission queue |
| err_cq | output | 1 | Pulse: invalid completion queue |
| evt_qid | output | 16 | Queue number of the current pulse |

## Verification
The decode is first driven with writes made while the controller is disabled, aimed at the admin pair and at I/O queues. This separates the enable gate from the existence check. With the controller enabled, the bench uses a partial created-queue map. Head and tail writes go to created queues, to uncreated queues, and to numbers past the last queue, so that each error kind can be told apart from the matching kick. The data patterns set the reserved upper half to show that it is masked and not flagged. Writes just below the window and at the highest valid pair test the window edges. A final disable confirms that every pointer clears.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned DB_BASE = 32'h1000;
  localparam int unsigned PTR_W   = 16;

  typedef enum logic [1:0] {
    EVT_NONE   = 2'd0,
    EVT_SQ_OK  = 2'd1,
    EVT_CQ_OK  = 2'd2,
    EVT_REJECT = 2'd3
  } evt_kind_t;
endpackage

// File: rtl/dbell_addr_dec.sv
module dbell_addr_dec #(
  parameter int ADDR_W = 14,
  parameter int NUM_Q  = 16,
  localparam int QID_W = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output logic              is_head,
  output logic [QID_W-1:0]  qid,
  output logic              qid_in_range
);
  logic [ADDR_W-1:0] rel;
  logic [1:0]        unused_lsb;

  always_comb begin
    in_window    = (addr >= ADDR_W'(dbell_pkg::DB_BASE));
    rel          = addr - ADDR_W'(dbell_pkg::DB_BASE);
    // bit 2 picks head vs tail; subtracting 4 for head only clears bit 2
    is_head      = rel[2];
    qid          = rel[ADDR_W-1:3];
    qid_in_range = ({1'b0, qid} < (QID_W+1)'(NUM_Q));
    unused_lsb   = rel[1:0];
  end
endmodule

// File: rtl/dbell_ptr_bank.sv
module dbell_ptr_bank #(
  parameter int NUM_Q = 16,
  parameter int PTR_W = 16,
  localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [PTR_W-1:0]       wr_val,
  output logic [NUM_Q*PTR_W-1:0] ptr_flat
);
  for (genvar i = 0; i < NUM_Q; i++) begin : g_ent
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             sel, ld;

    always_comb begin
      sel   = wr_en && (wr_idx == IDX_W'(i));
      ld    = clr || sel;
      ptr_d = clr ? '0 : wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ptr_q <= '0;
      else if (ld) ptr_q <= ptr_d;
    end

    assign ptr_flat[i*PTR_W +: PTR_W] = ptr_q;

    assert_ptr_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (ptr_flat[i*PTR_W +: PTR_W] == '0));
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!clr && !(wr_en && wr_idx == IDX_W'(i))) |->
        $stable(ptr_flat[i*PTR_W +: PTR_W]));
  end
endmodule

// File: rtl/dbell_decoder.sv
module dbell_decoder #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int NUM_Q  = 16,
  localparam int PTR_W = dbell_pkg::PTR_W,
  localparam int QID_W = ADDR_W - 3,
  localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   ctrl_enable,
  input  logic [NUM_Q-1:0]       sq_created,
  input  logic [NUM_Q-1:0]       cq_created,
  output logic [NUM_Q*PTR_W-1:0] sq_tail_flat,
  output logic [NUM_Q*PTR_W-1:0] cq_head_flat,
  output logic                   sq_kick,
  output logic                   cq_kick,
  output logic                   err_sq,
  output logic                   err_cq,
  output logic [15:0]            evt_qid
);
  import dbell_pkg::*;

  logic             in_window, is_head, qid_in_range;
  logic [QID_W-1:0] qid;
  logic [IDX_W-1:0] idx;
  logic             exists, hit, accept;
  logic             sq_wr, cq_wr;
  evt_kind_t        kind_d;
  logic             sq_kick_d, cq_kick_d, err_sq_d, err_cq_d;
  logic             sq_kick_q, cq_kick_q, err_sq_q, err_cq_q;
  logic [15:0]      qid_q;
  logic [PTR_W-1:0] ptr_val;
  logic             unused_hi;

  dbell_addr_dec #(.ADDR_W(ADDR_W), .NUM_Q(NUM_Q)) u_dec (
    .addr(wr_addr), .in_window(in_window), .is_head(is_head),
    .qid(qid), .qid_in_range(qid_in_range)
  );

  always_comb begin
    idx       = qid[IDX_W-1:0];
    hit       = wr_en && in_window;
    exists    = qid_in_range && (is_head ? cq_created[idx] : sq_created[idx]);
    accept    = hit && ctrl_enable && exists;
    sq_wr     = accept && !is_head;
    cq_wr     = accept && is_head;
    ptr_val   = wr_data[PTR_W-1:0];
    unused_hi = ^wr_data[DATA_W-1:PTR_W];
    if (!hit)        kind_d = EVT_NONE;
    else if (!accept) kind_d = EVT_REJECT;
    else if (is_head) kind_d = EVT_CQ_OK;
    else              kind_d = EVT_SQ_OK;
    sq_kick_d = (kind_d == EVT_SQ_OK);
    cq_kick_d = (kind_d == EVT_CQ_OK);
    err_sq_d  = (kind_d == EVT_REJECT) && !is_head;
    err_cq_d  = (kind_d == EVT_REJECT) && is_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_kick_q <= 1'b0;
      cq_kick_q <= 1'b0;
      err_sq_q  <= 1'b0;
      err_cq_q  <= 1'b0;
    end else begin
      sq_kick_q <= sq_kick_d;
      cq_kick_q <= cq_kick_d;
      err_sq_q  <= err_sq_d;
      err_cq_q  <= err_cq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   qid_q <= '0;
    else if (hit) qid_q <= 16'(qid);
  end

  dbell_ptr_bank #(.NUM_Q(NUM_Q), .PTR_W(PTR_W)) u_sq_bank (
    .clk(clk), .rst_n(rst_n), .clr(!ctrl_enable), .wr_en(sq_wr),
    .wr_idx(idx), .wr_val(ptr_val), .ptr_flat(sq_tail_flat)
  );

  dbell_ptr_bank #(.NUM_Q(NUM_Q), .PTR_W(PTR_W)) u_cq_bank (
    .clk(clk), .rst_n(rst_n), .clr(!ctrl_enable), .wr_en(cq_wr),
    .wr_idx(idx), .wr_val(ptr_val), .ptr_flat(cq_head_flat)
  );

  assign sq_kick = sq_kick_q;
  assign cq_kick = cq_kick_q;
  assign err_sq  = err_sq_q;
  assign err_cq  = err_cq_q;
  assign evt_qid = qid_q;

  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sq_kick, cq_kick, err_sq, err_cq}));
  assert_pulse_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_kick || cq_kick || err_sq || err_cq) |-> $past(wr_en));
  assert_reject_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_window && !ctrl_enable) |=> (err_sq || err_cq));
  assert_kick_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_kick || cq_kick) |-> $past(ctrl_enable));
  assert_outside_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_window) |=> !(sq_kick || cq_kick || err_sq || err_cq));
endmodule

// File: tb/dbell_decoder_tb.sv
module dbell_decoder_tb;
  localparam int NQ = 16;

  typedef struct {
    logic [3:0]  pulses; // {sq_kick, cq_kick, err_sq, err_cq}
    logic [15:0] qid;
    string       req;
  } exp_t;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [13:0]        wr_addr = '0;
  logic [31:0]        wr_data = '0;
  logic               ctrl_enable = 1'b0;
  logic [NQ-1:0]      sq_created = '0;
  logic [NQ-1:0]      cq_created = '0;
  logic [NQ*16-1:0]   sq_tail_flat, cq_head_flat;
  logic               sq_kick, cq_kick, err_sq, err_cq;
  logic [15:0]        evt_qid;

  int   n_cmp = 0;
  int   n_bad = 0;
  exp_t exp_q[$];
  logic [15:0] sq_m [NQ];
  logic [15:0] cq_m [NQ];

  always #10 clk = ~clk;

  dbell_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_enable(ctrl_enable), .sq_created(sq_created),
    .cq_created(cq_created), .sq_tail_flat(sq_tail_flat),
    .cq_head_flat(cq_head_flat), .sq_kick(sq_kick), .cq_kick(cq_kick),
    .err_sq(err_sq), .err_cq(err_cq), .evt_qid(evt_qid)
  );

  // monitor: compares pulses against the scoreboard every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] act;
      act = {sq_kick, cq_kick, err_sq, err_cq};
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (act !== e.pulses || (e.pulses != 0 && evt_qid !== e.qid)) begin
          n_bad++;
          $display("FAIL %s: pulses=%b qid=%0d expected pulses=%b qid=%0d",
                   e.req, act, evt_qid, e.pulses, e.qid);
        end
      end else if (act != 4'b0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R8: stray pulses=%b expected 0000", act);
      end
    end
  end

  task automatic check_ptrs(input string req);
    for (int i = 0; i < NQ; i++) begin
      n_cmp += 2;
      if (sq_tail_flat[i*16 +: 16] !== sq_m[i]) begin
        n_bad++;
        $display("FAIL %s: sq%0d tail=%h expected %h", req, i,
                 sq_tail_flat[i*16 +: 16], sq_m[i]);
      end
      if (cq_head_flat[i*16 +: 16] !== cq_m[i]) begin
        n_bad++;
        $display("FAIL %s: cq%0d head=%h expected %h", req, i,
                 cq_head_flat[i*16 +: 16], cq_m[i]);
      end
    end
  endtask

  // driver: one write, expectation from the requirement rules
  task automatic do_write(input logic [13:0] a, input logic [31:0] d,
                          input string req);
    exp_t e;
    int   rel, q;
    logic head, ok;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    e.req = req; e.qid = '0; e.pulses = 4'b0000;
    if (a >= 14'h1000) begin
      rel  = int'(a) - 32'h1000;
      head = rel[2];
      q    = rel >> 3;
      e.qid = 16'(q);
      ok = ctrl_enable && q < NQ && (head ? cq_created[q] : sq_created[q]);
      if (ok && head) begin e.pulses = 4'b0100; cq_m[q] = d[15:0]; end
      else if (ok)    begin e.pulses = 4'b1000; sq_m[q] = d[15:0]; end
      else if (head)  e.pulses = 4'b0001;
      else            e.pulses = 4'b0010;
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    exp_q.push_back(e);
    check_ptrs(req);
  endtask

  task automatic set_enable(input logic v);
    @(negedge clk);
    ctrl_enable = v;
    @(posedge clk);
    #1;
    if (!v) for (int i = 0; i < NQ; i++) begin sq_m[i] = '0; cq_m[i] = '0; end
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NQ; i++) begin sq_m[i] = '0; cq_m[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check_ptrs("R9 reset");
    @(negedge clk);
    rst_n = 1'b1;
    sq_created = 16'h800B; // queues 0,1,3,15
    cq_created = 16'h8007; // queues 0,1,2,15

    // disabled: admin and I/O doorbells rejected (R6)
    do_write(14'h1000, 32'h0000_0005, "R6 admin tail off");
    do_write(14'h1004, 32'h0000_0003, "R6 admin head off");
    do_write(14'h1008, 32'h0000_0007, "R6 io tail off");
    do_write(14'h100C, 32'h0000_0009, "R6 io head off");

    set_enable(1'b1);
    // accepted writes (R2 R4 R5), reserved bits set (R3)
    do_write(14'h1000, 32'hDEAD_0011, "R4 R3 admin tail");
    do_write(14'h1004, 32'hFFFF_0022, "R5 R3 admin head");
    do_write(14'h1008, 32'h0000_0033, "R4 R2 sq1 tail");
    do_write(14'h100C, 32'h1234_0044, "R5 R2 cq1 head");
    do_write(14'h1018, 32'h0000_0055, "R4 R2 sq3 tail");
    do_write(14'h1014, 32'h0000_0066, "R5 R2 cq2 head");
    do_write(14'h107B, 32'h0000_ABCD, "R2 R4 sq15 unaligned");
    do_write(14'h107C, 32'hFFFF_FFFF, "R5 R3 cq15 head");
    // uncreated and out of range (R7)
    do_write(14'h101C, 32'h0000_0077, "R7 cq3 uncreated");
    do_write(14'h1010, 32'h0000_0088, "R7 sq2 uncreated");
    do_write(14'h1080, 32'h0000_0099, "R7 sq16 range");
    do_write(14'h3FFC, 32'h0000_0099, "R7 cq top range");
    // below window (R1)
    do_write(14'h0FFC, 32'h0000_00AA, "R1 below window");
    do_write(14'h0014, 32'h0000_00BB, "R1 ctrl reg");
    // back-to-back mix
    do_write(14'h1000, 32'h0000_0012, "R4 admin tail again");
    do_write(14'h1000, 32'h0000_0013, "R4 admin tail b2b");

    set_enable(1'b0);
    check_ptrs("R9 clear on disable");
    do_write(14'h1008, 32'h0000_0001, "R6 after disable");

    repeat (3) @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R8: %0d pulses missing, expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule